// File: doc/BRIEF.md
# External Sync Detect and Vertical Reset

This block decides whether the camera's vertical timing runs free from its own line counter or follows an external reference. It watches three board pins: a vertical reference pin that can carry either composite sync or a vertical drive pulse, a horizontal reference pin, and a sync-type select pin. From the level activity on these pins it settles on one of three sync modes, and it reports whether an external reference is in use.

In a locked mode the block issues a one-cycle vertical reset strobe to the downstream vertical counter. With composite sync, the strobe is timed from the falling edge of the vertical pulse that the sync separator extracts. The 60 Hz standard places it 259 lines after that edge. The 50 Hz standard places it 309 lines after. With separate VD/HD references, the strobe lands on the first line boundary after a falling VD edge is seen. In that mode the field parity is set from where in the line that edge fell. Line timing comes from the internal horizontal counter as a one-cycle line strobe and a half-line level.

Top module: `ext_sync_vreset`

## Requirements
- R1: Under reset, `sync_mode` is 0, `ext_sync` is low, `vreset` is low and `odd_field` is high.
- R2: Mode codes are 0 for free-running, 1 for composite lock and 2 for VD/HD lock. The code 3 never appears. Free-running means both reference pins stay high and the select pin is low. Composite lock means the vertical pin shows low levels, the horizontal pin stays high and the select pin is low. VD/HD lock means both reference pins show low levels and the select pin is high. `ext_sync` is high exactly when the mode is not 0.
- R3: Pin activity is judged over windows of WIN_LINES line strobes. The mode changes only at the end of a window, and only when the same recognised pattern was seen in two consecutive windows. A single window with a different or unrecognised pattern leaves the mode unchanged.
- R4: In composite lock with `std50` low, `vreset` rises in the cycle after the CS_LINES_60-th line strobe that follows the falling edge of `vsep_n`.
- R5: In composite lock with `std50` high, the count is CS_LINES_50 line strobes instead.
- R6: In VD/HD lock, a falling edge on `vref_pin` reaches the trigger point SYNC_STAGES+1 clock edges after it is driven. `vreset` then rises in the cycle after the first line strobe that follows the trigger.
- R7: In VD/HD lock, `odd_field` is updated together with `vreset`. It becomes 1 if `line_half` was 0 at the trigger and 0 if `line_half` was 1. In composite lock, `odd_field` keeps its value.
- R8: Edges that do not belong to the current mode produce no `vreset`. This covers `vref_pin` edges in composite lock, `vsep_n` edges in VD/HD lock, and any edge in free-running mode.
- R9: In VD/HD lock a field of any length is followed. No `vreset` occurs without a VD falling edge, and a window containing no VD pulse does not change the mode.
- R10: `vreset` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| line_tick | input | 1 | One-cycle strobe at each line boundary of the internal counter |
| line_half | input | 1 | High during the second half of the current line |
| std50 | input | 1 | Low for the 60 Hz standard, high for the 50 Hz standard |
| vref_pin | input | 1 | Vertical reference or composite sync pin; reads high when open |
| href_pin | input | 1 | Horizontal reference pin; reads high when open |
| sel_pin | input | 1 | Sync-type select pin: high for VD/HD references; reads low when open |
| vsep_n | input | 1 | Active-low vertical pulse from the sync separator |
| sync_mode | output | 2 | Current sync mode code |
| ext_sync | output | 1 | High while locked to an external reference |
| vreset | output | 1 | One-cycle vertical counter reset strobe |
| odd_field | output | 1 | Field parity: high for odd |

## Verification
The bench numbers every rising edge and predicts the exact edge after which each strobe becomes visible. For composite lock that edge is the D-th line-strobe edge after the edge that sees `vsep_n` fall. For VD/HD lock it is the first line-strobe edge after the trigger, which comes SYNC_STAGES+1 edges after the pin falls. Stimulus edges are placed mid-line so that none of them coincides with a line strobe. Mode changes depend on window alignment, so they are checked only after three full windows have elapsed. All outputs are sampled on the falling clock edge.

// File: rtl/esync_pkg.sv
package esync_pkg;
  typedef enum logic [1:0] {
    SM_FREE  = 2'd0,
    SM_CSYNC = 2'd1,
    SM_VDHD  = 2'd2,
    SM_BAD   = 2'd3
  } sync_mode_e;
endpackage

// File: rtl/esync_pin_sync.sv
module esync_pin_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= {STAGES{RST_VAL}};
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/esync_mode_detect.sv
module esync_mode_detect import esync_pkg::*; #(
  parameter int WIN_LINES = 263
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       line_tick,
  input  logic       href_s,
  input  logic       vref_s,
  input  logic       sel_s,
  output sync_mode_e mode_o,
  output logic       ext_o
);
  localparam int WW = (WIN_LINES > 2) ? $clog2(WIN_LINES) : 1;
  localparam logic [WW-1:0] WLAST = WW'(WIN_LINES - 1);

  logic [WW-1:0] wcnt;
  logic          h_seen, v_seen;
  sync_mode_e    cand, last_cand, mode_q;
  logic          ext_q;
  logic          win_end;

  assign win_end = line_tick && (wcnt == WLAST);

  // classify the activity collected over one window
  always_comb begin
    if (sel_s && h_seen && v_seen)          cand = SM_VDHD;
    else if (!sel_s && !h_seen && v_seen)   cand = SM_CSYNC;
    else if (!sel_s && !h_seen && !v_seen)  cand = SM_FREE;
    else                                    cand = SM_BAD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt      <= '0;
      h_seen    <= 1'b0;
      v_seen    <= 1'b0;
      last_cand <= SM_BAD;
      mode_q    <= SM_FREE;
      ext_q     <= 1'b0;
    end else if (win_end) begin
      wcnt      <= '0;
      h_seen    <= ~href_s;
      v_seen    <= ~vref_s;
      last_cand <= cand;
      if (cand != SM_BAD && cand == last_cand) begin
        mode_q <= cand;
        ext_q  <= (cand != SM_FREE);
      end
    end else begin
      if (line_tick) wcnt <= wcnt + 1'b1;
      h_seen <= h_seen | ~href_s;
      v_seen <= v_seen | ~vref_s;
    end
  end

  assign mode_o = mode_q;
  assign ext_o  = ext_q;
endmodule

// File: rtl/esync_vreset_timer.sv
module esync_vreset_timer import esync_pkg::*; #(
  parameter int CS_LINES_60 = 259,
  parameter int CS_LINES_50 = 309
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       line_tick,
  input  logic       line_half,
  input  logic       std50,
  input  sync_mode_e mode,
  input  logic       cs_fall,
  input  logic       vd_fall,
  output logic       vreset_o,
  output logic       odd_o
);
  localparam int DMAX = (CS_LINES_60 > CS_LINES_50) ? CS_LINES_60 : CS_LINES_50;
  localparam int CW   = $clog2(DMAX + 1);

  logic [CW-1:0] cnt, cnt_nx, tgt;
  logic          armed, par_pend, par_val, vreset_q, odd_q;
  sync_mode_e    arm_mode;
  logic          trig;

  assign trig = (mode == SM_CSYNC && cs_fall) || (mode == SM_VDHD && vd_fall);
  assign cnt_nx = cnt + 1'b1;

  always_comb begin
    if (arm_mode == SM_VDHD) tgt = CW'(1);
    else if (std50)          tgt = CW'(CS_LINES_50);
    else                     tgt = CW'(CS_LINES_60);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      armed    <= 1'b0;
      arm_mode <= SM_FREE;
      par_pend <= 1'b0;
      par_val  <= 1'b1;
      vreset_q <= 1'b0;
      odd_q    <= 1'b1;
    end else begin
      vreset_q <= 1'b0;
      if (trig) begin
        armed    <= 1'b1;
        arm_mode <= mode;
        cnt      <= '0;
        par_pend <= (mode == SM_VDHD);
        par_val  <= ~line_half;
      end else if (mode != arm_mode) begin
        armed <= 1'b0;
      end else if (armed && line_tick) begin
        if (cnt_nx == tgt) begin
          armed    <= 1'b0;
          vreset_q <= 1'b1;
          if (par_pend) odd_q <= par_val;
        end else begin
          cnt <= cnt_nx;
        end
      end
    end
  end

  assign vreset_o = vreset_q;
  assign odd_o    = odd_q;
endmodule

// File: rtl/ext_sync_vreset.sv
module ext_sync_vreset import esync_pkg::*; #(
  parameter int SYNC_STAGES = 2,
  parameter int WIN_LINES   = 263,
  parameter int CS_LINES_60 = 259,
  parameter int CS_LINES_50 = 309
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       line_tick,
  input  logic       line_half,
  input  logic       std50,
  input  logic       vref_pin,
  input  logic       href_pin,
  input  logic       sel_pin,
  input  logic       vsep_n,
  output logic [1:0] sync_mode,
  output logic       ext_sync,
  output logic       vreset,
  output logic       odd_field
);
  localparam int NPIN = 3;

  logic [NPIN-1:0] pins_s;
  logic            href_s, vref_s, sel_s;
  logic            vref_d, vsep_d;
  logic            vd_fall, cs_fall;
  sync_mode_e      mode;

  // open pins idle as: select low, vertical high, horizontal high
  esync_pin_sync #(
    .W(NPIN), .STAGES(SYNC_STAGES), .RST_VAL(3'b011)
  ) u_sync (
    .clk(clk), .rst(rst),
    .din({sel_pin, vref_pin, href_pin}),
    .dout(pins_s)
  );
  assign href_s = pins_s[0];
  assign vref_s = pins_s[1];
  assign sel_s  = pins_s[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      vref_d <= 1'b1;
      vsep_d <= 1'b1;
    end else begin
      vref_d <= vref_s;
      vsep_d <= vsep_n;
    end
  end
  assign vd_fall = vref_d & ~vref_s;
  assign cs_fall = vsep_d & ~vsep_n;

  esync_mode_detect #(.WIN_LINES(WIN_LINES)) u_det (
    .clk(clk), .rst(rst), .line_tick(line_tick),
    .href_s(href_s), .vref_s(vref_s), .sel_s(sel_s),
    .mode_o(mode), .ext_o(ext_sync)
  );

  esync_vreset_timer #(
    .CS_LINES_60(CS_LINES_60), .CS_LINES_50(CS_LINES_50)
  ) u_tmr (
    .clk(clk), .rst(rst), .line_tick(line_tick), .line_half(line_half),
    .std50(std50), .mode(mode), .cs_fall(cs_fall), .vd_fall(vd_fall),
    .vreset_o(vreset), .odd_o(odd_field)
  );

  assign sync_mode = mode;
endmodule

// File: rtl/esync_checker.sv
module esync_checker (
  input logic       clk,
  input logic       rst,
  input logic       line_tick,
  input logic [1:0] mode,
  input logic       ext,
  input logic       vreset,
  input logic       odd
);
  assert_ext_flag_R2: assert property (@(posedge clk) disable iff (rst)
    ext == (mode != 2'd0));

  assert_mode_legal_R2: assert property (@(posedge clk) disable iff (rst)
    mode != 2'd3);

  assert_mode_on_tick_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(mode) |-> $past(line_tick));

  assert_parity_with_reset_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(odd) |-> vreset);

  assert_free_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd0 && $past(mode) == 2'd0) |-> !vreset);

  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    vreset |=> !vreset);
endmodule

bind ext_sync_vreset esync_checker u_chk (
  .clk(clk), .rst(rst), .line_tick(line_tick), .mode(sync_mode),
  .ext(ext_sync), .vreset(vreset), .odd(odd_field)
);

// File: tb/tb_ext_sync_vreset.sv
module tb_ext_sync_vreset;
  localparam int LINE = 16;
  localparam int WIN  = 24;
  localparam int D60  = 12;
  localparam int D50  = 15;
  localparam int SYNC = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic line_tick = 1'b0, line_half = 1'b0, std50 = 1'b0;
  logic href_pin = 1'b1, sel_pin = 1'b0, vsep_n = 1'b1;
  logic cs_wave = 1'b1, vd_wave = 1'b1, vref_pin;
  logic cs_en = 1'b0, h_en = 1'b0;
  logic [1:0] sync_mode;
  logic ext_sync, vreset, odd_field;

  int cyc = 0;
  int n_chk = 0, n_bad = 0;
  bit sb_on = 1'b0;
  bit odd_exp = 1'b1;

  typedef struct { int at; bit odd; string tag; } exp_t;
  exp_t q[$];

  assign vref_pin = cs_wave & vd_wave;

  ext_sync_vreset #(
    .SYNC_STAGES(SYNC), .WIN_LINES(WIN), .CS_LINES_60(D60), .CS_LINES_50(D50)
  ) dut (
    .clk(clk), .rst(rst), .line_tick(line_tick), .line_half(line_half),
    .std50(std50), .vref_pin(vref_pin), .href_pin(href_pin), .sel_pin(sel_pin),
    .vsep_n(vsep_n), .sync_mode(sync_mode), .ext_sync(ext_sync),
    .vreset(vreset), .odd_field(odd_field)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // line timing and background pin waveforms, set up for the next edge
  always @(negedge clk) begin
    line_tick <= ((cyc + 1) % LINE == 0);
    line_half <= ((cyc + 1) % LINE >= LINE / 2);
    cs_wave   <= !(cs_en && ((cyc + 1) % LINE == 4 || (cyc + 1) % LINE == 5));
    href_pin  <= !(h_en && ((cyc + 1) % LINE == 2 || (cyc + 1) % LINE == 3));
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: every strobe must match the head of the scoreboard
  always @(negedge clk) begin
    if (!rst && sb_on && vreset) begin
      if (q.size() == 0) begin
        chk(1'b0, "R8", "unexpected vreset at cycle", cyc, -1);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(cyc == e.at, e.tag, "vreset cycle", cyc, e.at);
        chk(odd_field == e.odd, "R7", "odd_field at vreset", odd_field, e.odd);
      end
    end
  end

  task automatic wait_phase(int ph);
    do @(negedge clk); while (cyc % LINE != ph);
  endtask

  task automatic cs_frame();
    int n;
    wait_phase(8);
    n = cyc;
    vsep_n <= 1'b0;
    if (sb_on) q.push_back('{n - n % LINE + (std50 ? D50 : D60) * LINE, odd_exp,
                             std50 ? "R5" : "R4"});
    repeat (2 * LINE) @(negedge clk);
    vsep_n <= 1'b1;
    repeat (18 * LINE) @(negedge clk);
  endtask

  task automatic vd_field(int ph, int lines, string tag);
    int n;
    wait_phase(ph);
    n = cyc;
    vd_wave <= 1'b0;
    if (sb_on) begin
      odd_exp = ((ph + SYNC + 1) % LINE < LINE / 2);
      q.push_back('{n - n % LINE + LINE, odd_exp, tag});
    end
    repeat (3 * LINE) @(negedge clk);
    vd_wave <= 1'b1;
    repeat ((lines - 3) * LINE) @(negedge clk);
  endtask

  task automatic settle();
    repeat (3 * WIN * LINE + LINE) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "WDOG", "watchdog expired at cycle", cyc, 0);
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(sync_mode == 2'd0, "R1", "sync_mode in reset", sync_mode, 0);
    chk(ext_sync == 1'b0, "R1", "ext_sync in reset", ext_sync, 0);
    chk(vreset == 1'b0, "R1", "vreset in reset", vreset, 0);
    chk(odd_field == 1'b1, "R1", "odd_field in reset", odd_field, 1);
    rst <= 1'b0;
    sb_on = 1'b1;

    // free-running: all pins open
    settle();
    chk(sync_mode == 2'd0, "R2", "free mode", sync_mode, 0);
    chk(ext_sync == 1'b0, "R2", "ext in free mode", ext_sync, 0);

    // single short disturbance: one odd window only
    vd_wave <= 1'b0;
    repeat (2) @(negedge clk);
    vd_wave <= 1'b1;
    settle();
    chk(sync_mode == 2'd0, "R3", "mode after one-window glitch", sync_mode, 0);

    // composite lock
    cs_en <= 1'b1;
    settle();
    chk(sync_mode == 2'd1, "R2", "composite mode", sync_mode, 1);
    chk(ext_sync == 1'b1, "R2", "ext in composite mode", ext_sync, 1);
    std50 <= 1'b0;
    cs_frame();
    cs_frame();
    std50 <= 1'b1;
    cs_frame();
    cs_frame();
    chk(q.size() == 0, "R4", "pending composite strobes", q.size(), 0);

    // VD/HD lock
    sb_on = 1'b0;
    cs_en <= 1'b0;
    h_en  <= 1'b1;
    sel_pin <= 1'b1;
    for (int i = 0; i < 5; i++) vd_field(2, 20, "R6");
    chk(sync_mode == 2'd2, "R2", "VD/HD mode", sync_mode, 2);
    chk(ext_sync == 1'b1, "R2", "ext in VD/HD mode", ext_sync, 1);
    sb_on = 1'b1;
    vd_field(2, 20, "R6");
    vd_field(9, 20, "R7");
    chk(odd_field == 1'b0, "R7", "even field parity held", odd_field, 0);
    // separator pulse must be ignored here
    wait_phase(8);
    vsep_n <= 1'b0;
    repeat (2 * LINE) @(negedge clk);
    vsep_n <= 1'b1;
    vd_field(2, 40, "R9");
    chk(sync_mode == 2'd2, "R9", "mode after long field", sync_mode, 2);
    vd_field(9, 20, "R9");
    vd_field(2, 20, "R7");
    chk(q.size() == 0, "R6", "pending VD/HD strobes", q.size(), 0);

    // back to free-running, separator edge must not reset
    h_en <= 1'b0;
    sel_pin <= 1'b0;
    settle();
    chk(sync_mode == 2'd0, "R2", "free mode again", sync_mode, 0);
    chk(ext_sync == 1'b0, "R2", "ext after return", ext_sync, 0);
    wait_phase(8);
    vsep_n <= 1'b0;
    repeat ((D60 + 2) * LINE) @(negedge clk);
    vsep_n <= 1'b1;
    chk(q.size() == 0, "R8", "pending strobes at end", q.size(), 0);
    finish_run();
  end
endmodule